// File: doc/BRIEF.md
# Shift-Register Terminal-Count Divider

This block divides an enabled clock stream by a fixed period PERIOD. It counts with the state of a maximal-length feedback shift register rather than a binary counter. No carry chain runs across the counter. The next-state logic is one parity tree over a few tapped bits, so the counter keeps up at clock rates where an adder would limit timing.

The register starts from a non-zero seed. At elaboration, a constant function walks the feedback function PERIOD−1 steps from that seed to find the terminal state. When the register holds the terminal state, the block raises a terminal-count flag. On the next enabled edge the register reloads the seed, so it skips the unused part of the maximal cycle. One complete count therefore lasts exactly PERIOD enabled cycles.

The divided output is a single-cycle enable for downstream logic. It is high whenever the terminal flag and the input enable are both high. With PERIOD set to 1 the seed is also the terminal state, so the divided enable simply follows the input enable.

Top module: `lfsr_tc_divider`

## Requirements
- R1: While `rst` is high at a clock edge, the state register loads START. After that edge, `state_o` equals START and `tc_o` is low, except when PERIOD is 1, where it is high.
- R2: On each edge with `en_i` high where `tc_o` is low, the state advances one step. The step shifts the state left by one bit, and the new bit 0 is the XOR of the bits selected by the mask TAPS. With a maximal mask, each step changes the state.
- R3: `state_o` is never all zeros.
- R4: On an edge with `en_i` high while `tc_o` is high, the state reloads START.
- R5: On an edge with `en_i` low, the state is held, so `state_o` and `tc_o` do not change.
- R6: `tc_o` is high exactly when PERIOD−1 enabled edges have passed since the state last held START at the beginning of a count.
- R7: `div_en_o` is high exactly when `tc_o` and `en_i` are both high. Successive `div_en_o` pulses are PERIOD enabled cycles apart.
- R8: With PERIOD of 1, `div_en_o` equals `en_i` on every cycle.
- R9: With PERIOD equal to 2^WIDTH−1, one count visits every non-zero state exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads START |
| en_i | input | 1 | Count enable |
| state_o | output | WIDTH | Current shift-register state |
| tc_o | output | 1 | Terminal-count flag; high while the terminal state is held |
| div_en_o | output | 1 | Divided enable; one cycle per PERIOD enabled cycles |

## Verification
The state and `tc_o` are registered, so each one reflects the enable seen at the previous edge. `div_en_o` also depends on `en_i` in the same cycle. The bench therefore changes `en_i` on the falling edge and samples every output shortly after that change, in the middle of the low phase. At that point the reference counter holds the number of enabled edges seen so far, and the expected values of all three outputs are due.

// File: rtl/lfsr_tc_divider.sv
module lfsr_tc_divider #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8,
  parameter logic [WIDTH-1:0] START = 1,
  parameter int PERIOD = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  output logic [WIDTH-1:0] state_o,
  output logic             tc_o,
  output logic             div_en_o
);

  function automatic logic [WIDTH-1:0] step(input logic [WIDTH-1:0] s);
    return {s[WIDTH-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [WIDTH-1:0] walk_to_end();
    logic [WIDTH-1:0] s;
    s = START;
    for (int i = 0; i < PERIOD - 1; i++) s = step(s);
    return s;
  endfunction

  localparam logic [WIDTH-1:0] TERM = walk_to_end();

  logic [WIDTH-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= START;
    else if (en_i) state_q <= tc_o ? START : step(state_q);
  end

  assign state_o  = state_q;
  assign tc_o     = (state_q == TERM);
  assign div_en_o = tc_o & en_i;

  p_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (en_i && tc_o) |=> state_q == START);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(state_q));
  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (en_i && !tc_o) |=> state_q != $past(state_q));

endmodule

// File: tb/lfsr_tc_divider_bench.sv
`timescale 1ns/1ps
module lfsr_tc_divider_bench;
  logic clk = 0, rst = 1, en = 0;
  always #2.5 clk = ~clk;

  localparam int NI = 4;
  int nper [NI] = '{100, 1, 255, 10};
  logic [7:0] seed [NI] = '{8'h01, 8'h5A, 8'h01, 8'h03};

  logic [7:0] s0, s1, s2;
  logic [3:0] s3;
  logic [7:0] st [NI];
  logic tc [NI], dv [NI];

  lfsr_tc_divider u_lfsr_tc_divider (.clk, .rst, .en_i(en), .state_o(s0), .tc_o(tc[0]), .div_en_o(dv[0]));
  lfsr_tc_divider #(.START(8'h5A), .PERIOD(1)) u_lfsr_tc_divider_p1
    (.clk, .rst, .en_i(en), .state_o(s1), .tc_o(tc[1]), .div_en_o(dv[1]));
  lfsr_tc_divider #(.PERIOD(255)) u_lfsr_tc_divider_full
    (.clk, .rst, .en_i(en), .state_o(s2), .tc_o(tc[2]), .div_en_o(dv[2]));
  lfsr_tc_divider #(.WIDTH(4), .TAPS(4'hC), .START(4'h3), .PERIOD(10)) u_lfsr_tc_divider_w4
    (.clk, .rst, .en_i(en), .state_o(s3), .tc_o(tc[3]), .div_en_o(dv[3]));

  assign st[0] = s0;
  assign st[1] = s1;
  assign st[2] = s2;
  assign st[3] = {4'b0, s3};

  int checks = 0, fails = 0;
  bit done = 0;
  int cnt [NI], gap [NI];
  bit gap_ok [NI], dv_s [NI];
  logic [7:0] prev_st [NI];
  bit prev_en;
  bit seen [256];

  task automatic chk(input bit ok, input string req, input int k, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s inst%0d actual=%0d expected=%0d at %0t", req, k, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < NI; k++) begin cnt[k] = 0; gap[k] = 0; gap_ok[k] = 0; end
    prev_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; en = 1;
    @(posedge clk); @(negedge clk); rst = 0; en = 0;
    clear_model();
    #0.5;
    for (int k = 0; k < NI; k++) begin
      chk(st[k] == seed[k], "R1 state", k, st[k], seed[k]);
      chk(tc[k] == (nper[k] == 1), "R1 tc", k, tc[k], nper[k] == 1);
      prev_st[k] = st[k];
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc == 1700) do_reset();
      @(negedge clk);
      en = (cyc % 9 != 4) && !(cyc > 2000 && cyc < 2010);
      #0.5;
      for (int k = 0; k < NI; k++) begin
        bit etc;
        etc = (cnt[k] == nper[k] - 1);
        chk(tc[k] == etc, "R6 tc", k, tc[k], etc);
        chk(dv[k] == (etc && en), "R7 div_en", k, dv[k], etc && en);
        if (k == 1) chk(dv[k] == en, "R8 div_en follows en", k, dv[k], en);
        chk(st[k] != 0, "R3 nonzero", k, st[k], 1);
        if (cnt[k] == 0) chk(st[k] == seed[k], "R4 restart", k, st[k], seed[k]);
        if (!prev_en) chk(st[k] == prev_st[k], "R5 hold", k, st[k], prev_st[k]);
        else if (nper[k] > 1) chk(st[k] != prev_st[k], "R2 advance", k, st[k], prev_st[k]);
        if (dv[k]) begin
          if (gap_ok[k]) chk(gap[k] + 1 == nper[k], "R7 spacing", k, gap[k] + 1, nper[k]);
          gap_ok[k] = 1;
        end
        dv_s[k] = dv[k];
        prev_st[k] = st[k];
        if (k == 2 && en) seen[st[k]] = 1;
      end
      prev_en = en;
      @(posedge clk);
      if (en) for (int k = 0; k < NI; k++) begin
        cnt[k] = (cnt[k] == nper[k] - 1) ? 0 : cnt[k] + 1;
        gap[k] = dv_s[k] ? 0 : gap[k] + 1;
      end
    end
    begin
      int n = 0;
      for (int v = 0; v < 256; v++) n += seen[v];
      chk(n == 255 && !seen[0], "R9 full sequence", 2, n, 255);
    end
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule